// File: doc/BRIEF.md
# Three-Channel Match Comparator Timer

This peripheral holds three 32-bit up-counters. Each counter has three match comparators, and each comparator has a status bit, an interrupt enable bit and a write-one-to-clear bit. A timer either restarts from a preload value on a comparator 0 match (periodic) or keeps counting (free-running). The counters live in a slow count clock domain (`tclk`). Each timer advances on a tick strobe, and a clock-select field picks that strobe from a bank of eight sources.

Software talks to the block over a plain 32-bit register bus on `clk`. The live counters are never read straight across the clock boundary. A write to a timer's capture address asks the count domain for a snapshot, and the snapshot returns through a toggle handshake. Later reads of that address, and of the timer's counter address, return the held value. Match events cross back to the bus domain as toggles, where they set sticky status bits. Each timer drives its own interrupt line.

Configuration registers (clock select, match values, preload, mode) are sampled directly by the count domain. They are quasi-static and must be changed only while the affected timer is stopped.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads 0 and all `irq` bits are low. Match register (n,m) sits at byte address 0x04 + 8n + 4(n+m) and reads back what was written.
- R2: Bit n of the enable register (0x84) runs timer n. A 0-to-1 change restarts the counter at 0. While the bit is 0 the counter holds its value.
- R3: An enabled counter advances by one on each selected tick. Clock-control (0x00) bits [1:0] pick the tick source for timer 0, bits [4:2] for timer 1 and bits [6:5] for timer 2. Ticks on other sources have no effect.
- R4: On a tick where the counter equals match value m, status bit m of that timer is set. A match value of D-1 therefore sets the status on the D-th tick after enabling.
- R5: When bit n of the mode register (0x88) is 0 (periodic), a comparator 0 match loads the counter instead of incrementing it. The load value is the preload value (0x4C + 4n) if preload control bit 0 (0x58 + 4n) is 1, and 0 otherwise. When the mode bit is 1, the counter keeps incrementing through matches.
- R6: Status sits at 0x34 + 4n, bits [2:0], and is read-only. Writing 1 to bit m at 0x74 + 4n clears status bit m. If a new match arrives in the same cycle as the clear, the match wins.
- R7: `irq[n]` is high while any status bit m of timer n has its enable bit m (0x40 + 4n) set. Writing 0 to the enable register masks the line from the next cycle.
- R8: Writing any value to 0xA4 + 4n requests a snapshot of counter n. Once the handshake completes, reads of 0xA4 + 4n and 0x28 + 4n return the count at the snapshot. That value holds until the next request.
- R9: A read strobe returns data on `bus_rdata` one cycle later. Unmapped or misaligned addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tclk | input | 1 | Count clock |
| tick_src | input | 8 | Tick strobes in the count domain |
| irq | output | 3 | Per-timer interrupt |

## Verification
The embedded assertions check the following on every cycle:
- a counter holds while its timer is disabled or no tick arrives;
- a counter restarts at zero when its timer is enabled;
- status is set after a crossed match event;
- write-one-to-clear works;
- a zero written to the enable register masks the interrupt.

The bench's scenarios show the rest: the register map, tick-source selection, comparator timing against D-1, reload from preload or from zero, free-running through a match, and snapshot values after the handshake. A behavioural model tracks counts, status bits and interrupt lines, and compares the interrupts on every quiet clock.

// File: rtl/match_timer.sv
module match_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [7:0]   bus_addr,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         tclk,
  input  logic [7:0]   tick_src,
  output logic [2:0]   irq
);
  localparam int NT = 3;
  localparam int NM = 3;
  localparam int NE = NT * NM;

  logic [5:0]   widx;
  logic         hit, we;
  logic [6:0]   ccr;
  logic [2:0]   cer, cmr, plc, rq_tgl;
  logic [W-1:0] mat [NT][NM];
  logic [W-1:0] pre [NT];
  logic [W-1:0] cap_b [NT];
  logic [2:0]   ier [NT];
  logic [2:0]   sts [NT];
  logic [NE-1:0] mt_s1, mt_s2, mt_q, set_ev;
  logic [2:0]   ak_s1, ak_s2, ak_q;
  logic [W-1:0] rmux;

  logic [2:0]   en_s1, en_s2, en_q, rq_s1, rq_s2, rq_q, ack_tgl, tk, go;
  logic [NE-1:0] mt_tgl;
  logic [W-1:0] cnt [NT];
  logic [W-1:0] cap_t [NT];

  assign widx   = bus_addr[7:2];
  assign hit    = (bus_addr[1:0] == 2'b00);
  assign we     = bus_wr && hit;
  assign set_ev = mt_s2 ^ mt_q;

  always_comb begin
    tk[0] = tick_src[{1'b0, ccr[1:0]}];
    tk[1] = tick_src[ccr[4:2]];
    tk[2] = tick_src[{1'b0, ccr[6:5]}];
    go    = en_s2 & en_q & tk;
    for (int n = 0; n < NT; n++) irq[n] = |(sts[n] & ier[n]);
  end

  // bus domain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr <= '0; cer <= '0; cmr <= '0; plc <= '0; rq_tgl <= '0;
      mt_s1 <= '0; mt_s2 <= '0; mt_q <= '0;
      ak_s1 <= '0; ak_s2 <= '0; ak_q <= '0;
      bus_rdata <= '0;
      for (int n = 0; n < NT; n++) begin
        pre[n] <= '0; cap_b[n] <= '0; ier[n] <= '0; sts[n] <= '0;
        for (int m = 0; m < NM; m++) mat[n][m] <= '0;
      end
    end else begin
      mt_s1 <= mt_tgl; mt_s2 <= mt_s1; mt_q <= mt_s2;
      ak_s1 <= ack_tgl; ak_s2 <= ak_s1; ak_q <= ak_s2;
      if (bus_rd) bus_rdata <= rmux;
      if (we && widx == 6'd0)  ccr <= bus_wdata[6:0];
      if (we && widx == 6'd33) cer <= bus_wdata[2:0];
      if (we && widx == 6'd34) cmr <= bus_wdata[2:0];
      for (int n = 0; n < NT; n++) begin
        if (ak_s2[n] != ak_q[n]) cap_b[n] <= cap_t[n];
        if (we && widx == 6'(16 + n)) ier[n] <= bus_wdata[2:0];
        if (we && widx == 6'(19 + n)) pre[n] <= bus_wdata;
        if (we && widx == 6'(22 + n)) plc[n] <= bus_wdata[0];
        if (we && widx == 6'(41 + n)) rq_tgl[n] <= ~rq_tgl[n];
        for (int m = 0; m < NM; m++) begin
          if (we && widx == 6'(1 + 3 * n + m)) mat[n][m] <= bus_wdata;
          if (set_ev[3 * n + m]) sts[n][m] <= 1'b1;
          else if (we && widx == 6'(29 + n) && bus_wdata[m]) sts[n][m] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rmux = '0;
    if (hit) begin
      if (widx == 6'd0)  rmux = W'(ccr);
      if (widx == 6'd33) rmux = W'(cer);
      if (widx == 6'd34) rmux = W'(cmr);
      for (int n = 0; n < NT; n++) begin
        for (int m = 0; m < NM; m++)
          if (widx == 6'(1 + 3 * n + m)) rmux = mat[n][m];
        if (widx == 6'(10 + n) || widx == 6'(41 + n)) rmux = cap_b[n];
        if (widx == 6'(13 + n)) rmux = W'(sts[n]);
        if (widx == 6'(16 + n)) rmux = W'(ier[n]);
        if (widx == 6'(19 + n)) rmux = pre[n];
        if (widx == 6'(22 + n)) rmux = W'(plc[n]);
      end
    end
  end

  // count domain
  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) begin
      en_s1 <= '0; en_s2 <= '0; en_q <= '0;
      rq_s1 <= '0; rq_s2 <= '0; rq_q <= '0;
      ack_tgl <= '0; mt_tgl <= '0;
      for (int n = 0; n < NT; n++) begin
        cnt[n] <= '0; cap_t[n] <= '0;
      end
    end else begin
      en_s1 <= cer; en_s2 <= en_s1; en_q <= en_s2;
      rq_s1 <= rq_tgl; rq_s2 <= rq_s1; rq_q <= rq_s2;
      for (int n = 0; n < NT; n++) begin
        for (int m = 0; m < NM; m++)
          if (go[n] && cnt[n] == mat[n][m]) mt_tgl[3 * n + m] <= ~mt_tgl[3 * n + m];
        if (en_s2[n] && !en_q[n]) cnt[n] <= '0;
        else if (go[n]) begin
          if (!cmr[n] && cnt[n] == mat[n][0]) cnt[n] <= plc[n] ? pre[n] : '0;
          else cnt[n] <= cnt[n] + 1'b1;
        end
        if (rq_s2[n] != rq_q[n]) begin
          cap_t[n]   <= cnt[n];
          ack_tgl[n] <= ~ack_tgl[n];
        end
      end
    end
  end

  for (genvar n = 0; n < NT; n++) begin : g_chk
    AST_RESTART_ZERO: assert property (@(posedge tclk) disable iff (!rst_n)
      (en_s2[n] && !en_q[n]) |=> (cnt[n] == '0)); // R2
    AST_HOLD_STOPPED: assert property (@(posedge tclk) disable iff (!rst_n)
      !en_s2[n] |=> $stable(cnt[n])); // R2
    AST_HOLD_NO_TICK: assert property (@(posedge tclk) disable iff (!rst_n)
      (en_s2[n] && en_q[n] && !tk[n]) |=> $stable(cnt[n])); // R3
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (we && widx == 6'(16 + n) && bus_wdata[2:0] == 3'b000) |=> !irq[n]); // R7
    for (genvar m = 0; m < NM; m++) begin : g_m
      AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev[3 * n + m] |=> sts[n][m]); // R4
      AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (we && widx == 6'(29 + n) && bus_wdata[m] && !set_ev[3 * n + m]) |=> !sts[n][m]); // R6
    end
  end
endmodule

// File: tb/tb_match_timer.sv
module tb_match_timer;
  logic clk = 1'b0, tclk = 1'b0, rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  tick_src = '0;
  logic [2:0]  irq;

  match_timer dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tclk(tclk),
    .tick_src(tick_src), .irq(irq));

  always #4 clk = ~clk;
  always #16 tclk = ~tclk;

  int checks = 0, errors = 0, quiet = 100;
  bit done = 0;

  // behavioural model
  logic [31:0] mcnt [3], mpre [3];
  logic [31:0] mmat [3][3];
  logic [2:0]  mier [3], msts [3];
  logic [2:0]  men = '0, mmode = '0, mplc = '0;
  logic [6:0]  mccr = '0;

  function automatic int a_mat(int n, int m); return 4 + 8 * n + 4 * (n + m); endfunction
  function automatic int sel_of(int t);
    if (t == 0) return int'(mccr[1:0]);
    if (t == 1) return int'(mccr[4:2]);
    return int'(mccr[6:5]);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (quiet > 0) quiet = quiet - 1;
    else if (rst_n && !done)
      for (int t = 0; t < 3; t++) chk("R7 irq", 32'(irq[t]), 32'(|(msts[t] & mier[t])));
  end

  task automatic wr(int a, logic [31:0] d);
    int i;
    quiet = 40;
    @(negedge clk); bus_addr = a[7:0]; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    quiet = 40;
    if (a % 4 == 0) begin
      i = a / 4;
      if (i == 0) mccr = d[6:0];
      if (i >= 1 && i <= 9) mmat[(i - 1) / 3][(i - 1) % 3] = d;
      if (i >= 16 && i <= 18) mier[i - 16] = d[2:0];
      if (i >= 19 && i <= 21) mpre[i - 19] = d;
      if (i >= 22 && i <= 24) mplc[i - 22] = d[0];
      if (i >= 29 && i <= 31) msts[i - 29] = msts[i - 29] & ~d[2:0];
      if (i == 34) mmode = d[2:0];
      if (i == 33) begin
        for (int t = 0; t < 3; t++) if (d[t] && !men[t]) mcnt[t] = '0;
        men = d[2:0];
      end
    end
    repeat (24) @(negedge clk);
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk); bus_addr = a[7:0]; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tick(int src, int n);
    quiet = 40;
    repeat (24) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      @(negedge tclk); tick_src[src] = 1'b1; quiet = 40;
      for (int t = 0; t < 3; t++)
        if (men[t] && sel_of(t) == src) begin
          for (int m = 0; m < 3; m++) if (mcnt[t] == mmat[t][m]) msts[t][m] = 1'b1;
          if (!mmode[t] && mcnt[t] == mmat[t][0]) mcnt[t] = mplc[t] ? mpre[t] : '0;
          else mcnt[t] = mcnt[t] + 1;
        end
      @(negedge tclk); tick_src[src] = 1'b0;
    end
    quiet = 40;
    repeat (24) @(negedge clk);
  endtask

  task automatic capture(int t, string req);
    logic [31:0] d;
    wr(32'hA4 + 4 * t, 32'h0);
    repeat (40) @(negedge clk);
    rd(32'hA4 + 4 * t, d);
    chk(req, d, mcnt[t]);
  endtask

  task automatic status(int t, string req);
    logic [31:0] d;
    rd(32'h34 + 4 * t, d);
    chk(req, d, 32'(msts[t]));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int t = 0; t < 3; t++) begin
      mcnt[t] = '0; mpre[t] = '0; mier[t] = '0; msts[t] = '0;
      for (int m = 0; m < 3; m++) mmat[t][m] = '0;
    end
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset irq", 32'(irq), 32'h0);
    rd(32'h84, d); chk("R1 reset enable", d, 32'h0);
    rd(a_mat(2, 2), d); chk("R1 reset match", d, 32'h0);
    status(0, "R1 reset status");

    for (int n = 0; n < 3; n++)
      for (int m = 0; m < 3; m++) wr(a_mat(n, m), 32'h1000_0000 + 32'(16 * n + m));
    for (int n = 0; n < 3; n++)
      for (int m = 0; m < 3; m++) begin
        rd(a_mat(n, m), d); chk("R1 match map", d, 32'h1000_0000 + 32'(16 * n + m));
      end

    wr(32'h00, 32'h0);
    wr(a_mat(0, 0), 4); wr(a_mat(0, 1), 7); wr(a_mat(0, 2), 9);
    wr(32'h40, 32'h3);
    wr(32'h88, 32'h1);
    wr(32'h84, 32'h1);
    tick(0, 4); status(0, "R4 no match before D ticks");
    tick(0, 1); status(0, "R4 match on D-th tick");
    capture(0, "R3 count after five ticks");
    tick(0, 3); status(0, "R4 comparator 1");
    tick(0, 2); status(0, "R4 comparator 2");
    capture(0, "R5 free-running past match");
    wr(32'h74, 32'h2); status(0, "R6 clear one bit");
    wr(32'h74, 32'h7); status(0, "R6 clear all");

    wr(32'h84, 32'h0);
    tick(0, 3); capture(0, "R2 hold while stopped");
    wr(32'h84, 32'h1); capture(0, "R2 restart at zero");

    wr(32'h00, 32'h74);
    wr(32'h84, 32'h7);
    tick(0, 3);
    capture(1, "R3 other source ignored");
    capture(0, "R3 timer 0 source 0");
    tick(5, 7);
    capture(1, "R3 timer 1 source 5");
    capture(0, "R3 timer 0 unaffected by source 5");

    wr(32'h84, 32'h0);
    wr(a_mat(2, 0), 3); wr(32'h4C + 8, 10); wr(32'h58 + 8, 1);
    wr(32'h88, 32'h2);
    wr(32'h84, 32'h4);
    tick(3, 6); capture(2, "R5 reload from preload");
    status(2, "R5 status on reload");

    wr(32'h74, 32'h7);
    wr(a_mat(0, 0), 2); wr(32'h58, 0);
    wr(32'h84, 32'h1);
    tick(0, 7); capture(0, "R5 reload to zero");

    wr(32'h84, 32'h0);
    wr(a_mat(1, 0), 2);
    wr(32'h84, 32'h2);
    tick(5, 6); capture(1, "R5 free-running timer 1");

    wr(32'h40, 32'h0);
    status(0, "R7 status pending while masked");
    repeat (10) @(negedge clk);
    chk("R7 masked irq", 32'(irq[0]), 32'h0);
    wr(32'h40, 32'h1);
    chk("R7 unmasked irq", 32'(irq[0]), 32'(msts[0][0]));

    tick(5, 2);
    rd(32'hA4 + 4, d); chk("R8 snapshot held", d, 32'd6);
    rd(32'h28 + 4, d); chk("R8 counter address", d, 32'd6);
    capture(1, "R8 new snapshot");

    rd(32'hFC, d); chk("R9 unmapped", d, 32'h0);
    rd(32'h85, d); chk("R9 misaligned", d, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule